// File: doc/BRIEF.md
# Shift-Chain Small FIFO

This block is a small synchronous first-in first-out queue. It does not use a circular buffer with separate read and write pointers. Its words sit in a chain of registers. Every accepted write moves the whole chain along by one place and puts the new word in the first place. One up/down occupancy counter says how many words are held. That same counter picks the chain position that drives the read data, so the oldest word held is always on the output.

A consumer reads the oldest word from `rd_data` while `is_empty` is low, and asserts `rd_take` to drop it. A producer asserts `wr_put` with `wr_data` while `is_full` is low. Both may be asserted in the same cycle. In that case the chain moves and the count stays the same, so the output still follows the oldest word. Depth and word width are parameters. A parameter also chooses whether the output is forced to zero or left unspecified while the queue is empty.

Top module: `srq_fifo`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `level` = 0, `is_empty` = 1 and `is_full` = 0.
- R2: `is_empty` is 1 exactly when `level` is 0. `is_full` is 1 exactly when `level` equals DEPTH (default 16).
- R3: A cycle with `wr_put`=1, `rd_take`=0 and the queue not full stores `wr_data` and raises `level` by one after the edge.
- R4: A cycle with `rd_take`=1, `wr_put`=0 and the queue not empty lowers `level` by one after the edge. It does not move the stored words.
- R5: A cycle with `wr_put`=1 and `rd_take`=1 while the queue is not empty removes the oldest word and stores `wr_data`. `level` is unchanged.
- R6: Words leave in the order they were stored. `rd_data` always shows the oldest word held.
- R7: A write while full without a read is ignored. `level` stays at DEPTH and the stored words are unchanged.
- R8: A read while empty is ignored. `level` stays 0 and does not wrap.
- R9: A simultaneous write and read while empty acts as a write alone. `level` becomes 1 and `rd_data` shows the written word.
- R10: With ZERO_WHEN_EMPTY=1 (default), `rd_data` is all zeros while `is_empty` is 1.
- R11: A simultaneous write and read while full is accepted. `level` stays at DEPTH and the oldest word is replaced in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_put | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_take | input | 1 | Read request; drops the oldest word |
| rd_data | output | WIDTH | Oldest stored word |
| is_full | output | 1 | Queue holds DEPTH words |
| is_empty | output | 1 | Queue holds no words |
| level | output | $clog2(DEPTH+1) | Number of words held |

## Verification
If the counter goes wrong, the chain position that drives the output is wrong. This shows on `rd_data` in the very next cycle as a word that is not the oldest one. It also shows on `level` and on the flags at once. If the chain moves when it should not, or fails to move when it should, the data order breaks. That is seen on the next read of the affected word. The bench drains the queue after each stress pattern so that every stored word is compared. The full-queue and empty-queue edge cases are each followed straight away by reads that expose any write that was wrongly accepted or rejected.

// File: rtl/srq_pkg.sv
package srq_pkg;
   function automatic int level_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/srq_occupancy.sv
module srq_occupancy #(
   parameter int DEPTH = 16,
   parameter int CW    = srq_pkg::level_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_put,
   input  logic          rd_take,
   output logic          shift_en,
   output logic [CW-1:0] level,
   output logic          is_full,
   output logic          is_empty
);
   localparam logic [CW-1:0] LVL_MAX = CW'(DEPTH);

   logic          take_ok;
   logic [CW-1:0] level_q;

   assign is_empty = (level_q == '0);
   assign is_full  = (level_q == LVL_MAX);
   assign take_ok  = rd_take & ~is_empty;
   assign shift_en = wr_put & (~is_full | take_ok);
   assign level    = level_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
      end else if (shift_en && !take_ok) begin
         level_q <= level_q + 1'b1;
      end else if (take_ok && !shift_en) begin
         level_q <= level_q - 1'b1;
      end
   end

   a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
      level_q <= LVL_MAX);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (level_q == '0));
   a_r3_put_grows: assert property (@(posedge clk) disable iff (rst)
      (wr_put && !rd_take && !is_full) |=> (level_q == $past(level_q) + 1'b1));
   a_r4_take_shrinks: assert property (@(posedge clk) disable iff (rst)
      (rd_take && !wr_put && !is_empty) |=> (level_q == $past(level_q) - 1'b1));
   a_r5_both_steady: assert property (@(posedge clk) disable iff (rst)
      (wr_put && rd_take && !is_empty) |=> $stable(level_q));
   a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
      (wr_put && !rd_take && is_full) |=> is_full);
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (rd_take && !wr_put && is_empty) |=> is_empty);
   a_r9_empty_both: assert property (@(posedge clk) disable iff (rst)
      (wr_put && rd_take && is_empty) |=> (level_q == CW'(1)));
endmodule

// File: rtl/srq_shift_chain.sv
module srq_shift_chain #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] cells [DEPTH]
);
   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (shift_en) cells[0] <= wr_data;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (shift_en) cells[s] <= cells[s-1];
         end
      end
   end

   a_r3_head_loads: assert property (@(posedge clk)
      shift_en |=> (cells[0] == $past(wr_data)));
   a_r4_tail_holds: assert property (@(posedge clk)
      !shift_en |=> $stable(cells[DEPTH-1]));
endmodule

// File: rtl/srq_tap_mux.sv
module srq_tap_mux #(
   parameter int WIDTH           = 8,
   parameter int DEPTH           = 16,
   parameter bit ZERO_WHEN_EMPTY = 1'b1,
   parameter int CW              = srq_pkg::level_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] cells [DEPTH],
   input  logic [CW-1:0]    level,
   input  logic             is_empty,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] idle_val;

   always_comb begin
      picked = '0;
      for (int t = 0; t < DEPTH; t++) begin
         if (level == CW'(t + 1)) picked = cells[t];
      end
   end

   if (ZERO_WHEN_EMPTY) begin : g_zero
      assign idle_val = '0;
      a_r10_zero_idle: assert property (@(posedge clk) disable iff (rst)
         is_empty |-> (rd_data == '0));
   end else begin : g_free
      assign idle_val = cells[0];
   end

   assign rd_data = is_empty ? idle_val : picked;
endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
   parameter int WIDTH           = 8,
   parameter int DEPTH           = 16,
   parameter bit ZERO_WHEN_EMPTY = 1'b1,
   parameter int CW              = srq_pkg::level_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_put,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_take,
   output logic [WIDTH-1:0] rd_data,
   output logic             is_full,
   output logic             is_empty,
   output logic [CW-1:0]    level
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("srq_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("srq_fifo: WIDTH must be at least 1");
   end
   if (CW != $clog2(DEPTH + 1)) begin : g_bad_cw
      $error("srq_fifo: CW must be left at its derived value");
   end

   logic             shift_en;
   logic [WIDTH-1:0] cells [DEPTH];

   srq_occupancy #(.DEPTH(DEPTH), .CW(CW)) occ_i (
      .clk(clk), .rst(rst), .wr_put(wr_put), .rd_take(rd_take),
      .shift_en(shift_en), .level(level), .is_full(is_full), .is_empty(is_empty)
   );

   srq_shift_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chain_i (
      .clk(clk), .shift_en(shift_en), .wr_data(wr_data), .cells(cells)
   );

   srq_tap_mux #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ZERO_WHEN_EMPTY(ZERO_WHEN_EMPTY), .CW(CW)) mux_i (
      .clk(clk), .rst(rst), .cells(cells), .level(level),
      .is_empty(is_empty), .rd_data(rd_data)
   );

   a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(is_full && is_empty));
   a_r11_full_both: assert property (@(posedge clk) disable iff (rst)
      (wr_put && rd_take && is_full) |=> is_full);
endmodule

// File: tb/srq_fifo_tb_top.sv
module srq_fifo_tb_top;
   localparam int W  = 8;
   localparam int D  = 16;
   localparam int CW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_put = 1'b0;
   logic          rd_take = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic          is_full, is_empty;
   logic [CW-1:0] level;

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] exp_q [$];

   always #5 clk = ~clk;

   srq_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk(clk), .rst(rst), .wr_put(wr_put), .wr_data(wr_data), .rd_take(rd_take),
      .rd_data(rd_data), .is_full(is_full), .is_empty(is_empty), .level(level)
   );

   task automatic check(input int act, input int exp, input string req, input string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      check(int'(level), exp_q.size(), req, "level");
      check(int'(is_empty), int'(exp_q.size() == 0), "R2", "is_empty");
      check(int'(is_full), int'(exp_q.size() == D), "R2", "is_full");
      if (exp_q.size() == 0) check(int'(rd_data), 0, "R10", "rd_data while empty");
      else check(int'(rd_data), int'(exp_q[0]), "R6", "head word");
   endtask

   task automatic step(input bit p, input bit t, input logic [W-1:0] d, input string req);
      bit take_ok, put_ok;
      logic [W-1:0] old;
      @(negedge clk);
      wr_put = p; rd_take = t; wr_data = d;
      #1;
      take_ok = t && (exp_q.size() > 0);
      put_ok  = p && ((exp_q.size() < D) || take_ok);
      if (take_ok) begin
         old = exp_q.pop_front();
         check(int'(rd_data), int'(old), "R6", "word read out");
      end
      if (put_ok) exp_q.push_back(d);
      @(posedge clk);
      #1;
      wr_put = 1'b0; rd_take = 1'b0;
      check_state(req);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(posedge clk);
      #1;
      check_state("R1");
      @(negedge clk); rst = 1'b0;

      // R8: read while empty
      step(1'b0, 1'b1, 8'h00, "R8");
      step(1'b0, 1'b1, 8'h00, "R8");
      // R9: both while empty
      step(1'b1, 1'b1, 8'hA5, "R9");
      check(int'(rd_data), 8'hA5, "R9", "written word visible");
      step(1'b0, 1'b1, 8'h00, "R4");

      // R3: fill to full
      for (int i = 0; i < D; i++) step(1'b1, 1'b0, 8'(8'h10 + i), "R3");
      // R7: writes while full are ignored
      step(1'b1, 1'b0, 8'hEE, "R7");
      step(1'b1, 1'b0, 8'hEF, "R7");
      // R11: both while full
      step(1'b1, 1'b1, 8'h70, "R11");
      step(1'b1, 1'b1, 8'h71, "R11");
      // R4: drain half
      for (int i = 0; i < D / 2; i++) step(1'b0, 1'b1, 8'h00, "R4");
      // R5: both while partly filled
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'(8'h80 + i), "R5");
      // drain fully to compare all words (R6)
      while (exp_q.size() > 0) step(1'b0, 1'b1, 8'h00, "R6");
      step(1'b0, 1'b1, 8'h00, "R8");

      // mixed pattern
      lfsr = 8'h5B;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(lfsr[0] | lfsr[3], lfsr[1] & ~lfsr[6], lfsr, "R6");
      end
      while (exp_q.size() > 0) step(1'b0, 1'b1, 8'h00, "R6");

      // reset mid-run
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'(8'hC0 + i), "R3");
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      exp_q.delete();
      check_state("R1");
      @(negedge clk); rst = 1'b0;
      step(1'b1, 1'b0, 8'h3C, "R3");
      step(1'b0, 1'b1, 8'h00, "R4");
      finish_run();
   end
endmodule